// File: doc/BRIEF.md
# RISC Integer ALU with Immediate Handling

This block is the combinational integer execution unit of a three-address load-store processor. In one evaluation it takes two register operands, a 16-bit instruction immediate, a 5-bit constant shift count and an operation selector. It returns a 32-bit result and a separate overflow-trap flag. Whatever reacts to the trap lives outside this block.

The unit covers several groups of operations:

- add and subtract, each in a trapping form and a wrapping form
- the bitwise operations and, or, xor and nor
- signed and unsigned set-on-less-than
- logical left, logical right and arithmetic right shifts, each with either a constant amount or a register amount
- placing an immediate into the upper half of a word

The immediate is widened according to the operation, not according to its signedness. Arithmetic and compare immediates are sign-extended. Bitwise immediates are zero-extended.

There is no state, so there are no states or transitions to name. A single adder is shared between the add, subtract and compare operations. A decode step drives that adder, a bitwise unit, a staged shifter and the immediate extender, and then selects one result.

Top module: `rix_alu`

## Requirements
- R1: `op_sel` encodings are 0 ADD, 1 ADDU, 2 SUB, 3 SUBU, 4 ADDI, 5 ADDIU, 6 AND, 7 OR, 8 XOR, 9 NOR, 10 ANDI, 11 ORI, 12 XORI, 13 SLT, 14 SLTU, 15 SLTI, 16 SLTIU, 17 LUI, 18 SLL, 19 SRL, 20 SRA, 21 SLLV, 22 SRLV, 23 SRAV. Any other code gives `result` 0 and `ovf_trap` 0.
- R2: ADD, SUB and ADDI raise `ovf_trap` on two's-complement overflow and still return the wrapped result. Overflow means both addends share a sign and the sum's sign differs; subtraction applies this test with the second operand negated.
- R3: ADDU, SUBU and ADDIU return the same wrapped result as their trapping counterparts, and `ovf_trap` stays 0.
- R4: ADDI, ADDIU, SLTI and SLTIU sign-extend `imm` from bit 15 to 32 bits. The extended immediate is the second operand and `opnd_a` is the first.
- R5: ANDI, ORI and XORI zero-extend `imm` to 32 bits.
- R6: LUI returns `imm` in bits 31:16 with bits 15:0 cleared, whatever the other inputs are.
- R7: SLT and SLTI return 1 when the first operand is below the second in two's complement, otherwise 0. SLTU and SLTIU compare as unsigned numbers. For example, 0xFFFFFFFF is below 1 when signed but not when unsigned.
- R8: AND, OR and XOR return the bitwise function of `opnd_a` and `opnd_b`. NOR returns the inverse of their OR.
- R9: SLL, SRL and SRA shift `opnd_b` by `shamt`. SRA fills the vacated bits with bit 31; SLL and SRL fill with zeros.
- R10: SLLV, SRLV and SRAV shift `opnd_b` by bits 4:0 of `opnd_a`; the upper bits of `opnd_a` are ignored.
- R11: The bitwise, compare, LUI and shift operations never raise `ovf_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation selector (encoding in R1) |
| opnd_a | input | 32 | First register operand; low bits give the variable shift amount |
| opnd_b | input | 32 | Second register operand; the value that shifts act on |
| imm | input | 16 | Instruction immediate |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Overflow exception flag for the trapping add and subtract forms |

## Verification
The trapping and wrapping forms of each add and subtract are run on the same operands: positive overflow, negative overflow and a plain sum. This shows that only the flag differs between the two forms. Immediates with bit 15 set are given to both arithmetic and bitwise operations, which separates sign extension from zero extension. The operand pair 0xFFFFFFFF and 1 goes through both compare forms to split the signed and unsigned orderings. Shifts use counts of 0, 4 and 31 on a value with bit 31 set, which separates the fill rules; a register amount with its upper bits set shows that only bits 4:0 are used.

// File: rtl/rix_pkg.sv
package rix_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
        OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI = 5'd10, OP_ORI  = 5'd11,
        OP_XORI  = 5'd12, OP_SLT   = 5'd13, OP_SLTU = 5'd14, OP_SLTI = 5'd15,
        OP_SLTIU = 5'd16, OP_LUI   = 5'd17, OP_SLL  = 5'd18, OP_SRL  = 5'd19,
        OP_SRA   = 5'd20, OP_SLLV  = 5'd21, OP_SRLV = 5'd22, OP_SRAV = 5'd23
    } op_e;

    typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logic_fn_e;
    typedef enum logic [1:0] {SH_LL, SH_RL, SH_RA} shift_kind_e;
    typedef enum logic [2:0] {
        SEL_NONE, SEL_SUM, SEL_LOGIC, SEL_LT_S, SEL_LT_U, SEL_UPPER, SEL_SHIFT
    } res_sel_e;

    typedef struct packed {
        res_sel_e    sel;
        logic        use_imm;
        logic        imm_sext;
        logic        do_sub;
        logic        trapping;
        logic_fn_e   lfn;
        shift_kind_e skind;
        logic        var_amt;
    } ctrl_t;
endpackage

// File: rtl/rix_imm_ext.sv
module rix_imm_ext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sext,
    output logic [DATA_W-1:0] ext
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        ext = {{PAD_W{sext & imm[IMM_W-1]}}, imm};
    end
endmodule

// File: rtl/rix_addsub.sv
module rix_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;
    logic [DATA_W-1:0] rhs_eff;

    always_comb begin
        rhs_eff      = sub ? ~rhs : rhs;
        {carry, sum} = {1'b0, lhs} + {1'b0, rhs_eff} + {{DATA_W{1'b0}}, sub};
        ovf          = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
    end
endmodule

// File: rtl/rix_logic.sv
module rix_logic
    import rix_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic_fn_e         fn,
    output logic [DATA_W-1:0] out
);
    always_comb begin
        unique case (fn)
            LG_AND:  out = lhs & rhs;
            LG_OR:   out = lhs | rhs;
            LG_XOR:  out = lhs ^ rhs;
            default: out = ~(lhs | rhs);
        endcase
    end
endmodule

// File: rtl/rix_shifter.sv
module rix_shifter
    import rix_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  logic [AMT_W-1:0]  amount,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] out
);
    localparam int MSB = DATA_W - 1;

    logic              fill;
    logic [DATA_W-1:0] stage [0:AMT_W];

    assign fill     = (kind == SH_RA) ? value[MSB] : 1'b0;
    assign stage[0] = value;

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int D = 1 << i;
        logic [DATA_W-1:0] moved;
        always_comb begin
            if (kind == SH_LL) moved = {stage[i][DATA_W-1-D:0], {D{1'b0}}};
            else               moved = {{D{fill}}, stage[i][MSB:D]};
        end
        assign stage[i+1] = amount[i] ? moved : stage[i];
    end

    assign out = stage[AMT_W];
endmodule

// File: rtl/rix_alu.sv
module rix_alu
    import rix_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [AMT_W-1:0]  shamt,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap
);
    localparam int LO_W = DATA_W - IMM_W;

    ctrl_t             ctl;
    logic [DATA_W-1:0] imm_x, rhs, sum, lgc, shf;
    logic              carry, ovf_raw;
    logic [AMT_W-1:0]  amt;

    // Decode (R1): one control word for each operation code
    always_comb begin
        ctl = '{sel: SEL_NONE, use_imm: 1'b0, imm_sext: 1'b0, do_sub: 1'b0,
                trapping: 1'b0, lfn: LG_AND, skind: SH_LL, var_amt: 1'b0};
        unique case (op_sel)
            OP_ADD:   begin ctl.sel = SEL_SUM; ctl.trapping = 1'b1; end
            OP_ADDU:  ctl.sel = SEL_SUM;
            OP_SUB:   begin ctl.sel = SEL_SUM; ctl.do_sub = 1'b1; ctl.trapping = 1'b1; end
            OP_SUBU:  begin ctl.sel = SEL_SUM; ctl.do_sub = 1'b1; end
            OP_ADDI:  begin ctl.sel = SEL_SUM; ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1;
                            ctl.trapping = 1'b1; end
            OP_ADDIU: begin ctl.sel = SEL_SUM; ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1; end
            OP_AND:   ctl.sel = SEL_LOGIC;
            OP_OR:    begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_OR; end
            OP_XOR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_XOR; end
            OP_NOR:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_NOR; end
            OP_ANDI:  begin ctl.sel = SEL_LOGIC; ctl.use_imm = 1'b1; end
            OP_ORI:   begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_OR; ctl.use_imm = 1'b1; end
            OP_XORI:  begin ctl.sel = SEL_LOGIC; ctl.lfn = LG_XOR; ctl.use_imm = 1'b1; end
            OP_SLT:   begin ctl.sel = SEL_LT_S; ctl.do_sub = 1'b1; end
            OP_SLTU:  begin ctl.sel = SEL_LT_U; ctl.do_sub = 1'b1; end
            OP_SLTI:  begin ctl.sel = SEL_LT_S; ctl.do_sub = 1'b1; ctl.use_imm = 1'b1;
                            ctl.imm_sext = 1'b1; end
            OP_SLTIU: begin ctl.sel = SEL_LT_U; ctl.do_sub = 1'b1; ctl.use_imm = 1'b1;
                            ctl.imm_sext = 1'b1; end
            OP_LUI:   ctl.sel = SEL_UPPER;
            OP_SLL:   ctl.sel = SEL_SHIFT;
            OP_SRL:   begin ctl.sel = SEL_SHIFT; ctl.skind = SH_RL; end
            OP_SRA:   begin ctl.sel = SEL_SHIFT; ctl.skind = SH_RA; end
            OP_SLLV:  begin ctl.sel = SEL_SHIFT; ctl.var_amt = 1'b1; end
            OP_SRLV:  begin ctl.sel = SEL_SHIFT; ctl.skind = SH_RL; ctl.var_amt = 1'b1; end
            OP_SRAV:  begin ctl.sel = SEL_SHIFT; ctl.skind = SH_RA; ctl.var_amt = 1'b1; end
            default:  ;
        endcase
    end

    // Immediate widening rule: R4 (sign) and R5 (zero)
    rix_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
        .imm(imm), .sext(ctl.imm_sext), .ext(imm_x)
    );

    assign rhs = ctl.use_imm ? imm_x : opnd_b;
    assign amt = ctl.var_amt ? opnd_a[AMT_W-1:0] : shamt;   // R10

    rix_addsub #(.DATA_W(DATA_W)) u_add (
        .lhs(opnd_a), .rhs(rhs), .sub(ctl.do_sub),
        .sum(sum), .carry(carry), .ovf(ovf_raw)
    );

    rix_logic #(.DATA_W(DATA_W)) u_lgc (
        .lhs(opnd_a), .rhs(rhs), .fn(ctl.lfn), .out(lgc)
    );

    rix_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shf (
        .value(opnd_b), .amount(amt), .kind(ctl.skind), .out(shf)
    );

    // Result select; trap only from the trapping forms (R2, R3)
    always_comb begin
        result   = '0;
        ovf_trap = ctl.trapping & ovf_raw;
        unique case (ctl.sel)
            SEL_SUM:   result = sum;
            SEL_LOGIC: result = lgc;
            SEL_LT_S:  result = {{(DATA_W-1){1'b0}}, sum[DATA_W-1] ^ ovf_raw};
            SEL_LT_U:  result = {{(DATA_W-1){1'b0}}, ~carry};
            SEL_UPPER: result = {imm, {LO_W{1'b0}}};
            SEL_SHIFT: result = shf;
            default:   result = '0;
        endcase
    end

    // Checks across decode, adder and output select
    always_comb begin
        if (ovf_trap) begin
            assert_trap_only_R2: assert (op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_ADDI)
                else $error("trap raised by a non-trapping operation");
        end
        if (ctl.sel == SEL_LOGIC || ctl.sel == SEL_SHIFT || ctl.sel == SEL_UPPER
            || ctl.sel == SEL_LT_S || ctl.sel == SEL_LT_U) begin
            assert_no_overflow_R11: assert (!ovf_trap)
                else $error("trap raised by bitwise, shift or compare");
        end
        if (op_sel == OP_LUI) begin
            assert_lui_low_R6: assert (result[LO_W-1:0] == '0)
                else $error("upper-immediate low half not clear");
        end
        if (ctl.sel == SEL_LT_S || ctl.sel == SEL_LT_U) begin
            assert_slt_bool_R7: assert (result[DATA_W-1:1] == '0)
                else $error("compare result not 0 or 1");
        end
    end
endmodule

// File: tb/rix_alu_test.sv
`timescale 1ns/1ps
module rix_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_sel = 5'd31;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf_trap;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    rix_alu uut (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
                 .shamt(shamt), .result(result), .ovf_trap(ovf_trap));

    task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i, input logic [4:0] s);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm = i; shamt = s;
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] exp_r, input logic exp_o);
        n_run++;
        if (result !== exp_r || ovf_trap !== exp_o) begin
            n_fail++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     req, result, ovf_trap, exp_r, exp_o);
        end
    endtask

    task automatic t_undefined;
        apply(5'd31, 32'hFFFF_FFFF, 32'h1234_5678, 16'hFFFF, 5'd3);
        check("R1 undefined code 31", 32'h0, 1'b0);
        apply(5'd24, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R1 undefined code 24", 32'h0, 1'b0);
    endtask

    task automatic t_trap_pairs;
        apply(5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R2 ADD positive overflow", 32'h8000_0000, 1'b1);
        apply(5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R3 ADDU wraps no trap", 32'h8000_0000, 1'b0);
        apply(5'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0);
        check("R2 SUB negative overflow", 32'h7FFF_FFFF, 1'b1);
        apply(5'd3, 32'h8000_0000, 32'h1, 16'h0, 5'd0);
        check("R3 SUBU wraps no trap", 32'h7FFF_FFFF, 1'b0);
        apply(5'd0, 32'd100, 32'hFFFF_FFF6, 16'h0, 5'd0);
        check("R2 ADD plain no overflow", 32'd90, 1'b0);
        apply(5'd2, 32'd5, 32'h8000_0000, 16'h0, 5'd0);
        check("R2 SUB of most negative overflows", 32'h8000_0005, 1'b1);
    endtask

    task automatic t_immediates;
        apply(5'd4, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        check("R2 R4 ADDI sign-extended overflow", 32'h7FFF_FFFF, 1'b1);
        apply(5'd5, 32'd5, 32'h0, 16'hFFFF, 5'd0);
        check("R3 R4 ADDIU sign-extended", 32'd4, 1'b0);
        apply(5'd10, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0);
        check("R5 ANDI zero-extended", 32'h0000_8000, 1'b0);
        apply(5'd11, 32'h1200_0000, 32'h0, 16'hF00F, 5'd0);
        check("R5 ORI zero-extended", 32'h1200_F00F, 1'b0);
        apply(5'd12, 32'hFFFF_0000, 32'h0, 16'hFFFF, 5'd0);
        check("R5 XORI zero-extended", 32'hFFFF_FFFF, 1'b0);
        apply(5'd17, 32'hDEAD_BEEF, 32'h1234_5678, 16'hABCD, 5'd7);
        check("R6 LUI", 32'hABCD_0000, 1'b0);
    endtask

    task automatic t_compare;
        apply(5'd13, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R7 SLT signed -1<1", 32'h1, 1'b0);
        apply(5'd14, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        check("R7 SLTU all-ones not below 1", 32'h0, 1'b0);
        apply(5'd13, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0);
        check("R7 R11 SLT across overflow", 32'h0, 1'b0);
        apply(5'd15, 32'd5, 32'h0, 16'hFFFF, 5'd0);
        check("R4 R7 SLTI 5 < -1", 32'h0, 1'b0);
        apply(5'd16, 32'd5, 32'h0, 16'hFFFF, 5'd0);
        check("R4 R7 SLTIU 5 < 0xFFFFFFFF", 32'h1, 1'b0);
    endtask

    task automatic t_logic;
        apply(5'd6, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 5'd0);
        check("R8 AND", 32'hF000_1200, 1'b0);
        apply(5'd7, 32'hF0F0_0000, 32'h0F00_000F, 16'h0, 5'd0);
        check("R8 OR", 32'hFFF0_000F, 1'b0);
        apply(5'd8, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0);
        check("R8 XOR", 32'h5555_5555, 1'b0);
        apply(5'd9, 32'hF0F0_0000, 32'h0F00_000F, 16'h0, 5'd0);
        check("R8 R11 NOR", 32'h000F_FFF0, 1'b0);
    endtask

    task automatic t_shifts;
        apply(5'd20, 32'h0, 32'h8000_0010, 16'h0, 5'd4);
        check("R9 SRA fills sign", 32'hF800_0001, 1'b0);
        apply(5'd19, 32'h0, 32'h8000_0010, 16'h0, 5'd4);
        check("R9 SRL fills zero", 32'h0800_0001, 1'b0);
        apply(5'd18, 32'h0, 32'h8000_0011, 16'h0, 5'd4);
        check("R9 SLL", 32'h0000_0110, 1'b0);
        apply(5'd20, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        check("R9 SRA by 31", 32'hFFFF_FFFF, 1'b0);
        apply(5'd18, 32'h0, 32'hDEAD_BEEF, 16'h0, 5'd0);
        check("R9 SLL by 0", 32'hDEAD_BEEF, 1'b0);
        apply(5'd21, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0, 5'd0);
        check("R10 SLLV uses low bits only", 32'h0000_0008, 1'b0);
        apply(5'd22, 32'h0000_0124, 32'h8000_0000, 16'h0, 5'd1);
        check("R10 SRLV ignores shamt", 32'h0800_0000, 1'b0);
        apply(5'd23, 32'h0000_003F, 32'h8000_0000, 16'h0, 5'd0);
        check("R10 R11 SRAV by 31", 32'hFFFF_FFFF, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_undefined();
        t_trap_pairs();
        t_immediates();
        t_compare();
        t_logic();
        t_shifts();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule